// File: doc/BRIEF.md
# Atomic Command and Tag Completion Register

This block is the host-facing register interface of a storage request scheduler. Software issues a whole request by writing one 64-bit command word. The block splits that word into its tag, opcode, length and sector address fields. It looks up the host DMA buffer base that software loaded earlier for that tag. It then pushes a one-cycle request descriptor toward the scheduler queue. Because the host address comes from a per-tag table, no part of a request needs a second bus write. As a result, many software threads can issue requests without a lock.

When the scheduler reports that a tag has finished, the block sets that tag's status bit and raises an interrupt. Reading the status register returns every bit that became set since the previous read and clears those bits in the same operation. Two concurrent readers therefore never both see the same completion. The block also remembers which tags are outstanding. A command that reuses a busy tag, or that names a tag beyond the table, is dropped and flagged in a sticky error bit.

Top module: `atomic_issue_regs`

## Requirements
- R1: The command word at register address 0 is decoded as bits [7:0] tag, [15:8] opcode, [31:16] length in 512-byte units and [63:32] internal sector address in 512-byte units. A single write of it with a free, in-range tag makes `req_valid` high for exactly the following cycle, carrying those fields.
- R2: A write to an address whose top bit is set loads the DMA base entry selected by the low address bits, taking the low `DMA_AW` bits of the write data. An issued request presents the entry of its own tag on `req_dma`.
- R3: A `done_valid` pulse sets the status bit of `done_tag` at the next clock edge.
- R4: A read of register address 1 returns the status bits on `reg_rdata` in the cycle after `reg_rd`, with bit t for tag t, zero above, and `reg_rvalid` high. The same read clears the bits it returned.
- R5: A completion that arrives in the same cycle as a status read is not returned by that read. It is returned by the next read.
- R6: `irq` is high whenever any status bit is set and falls only after a status read leaves no bit set.
- R7: A command whose tag is outstanding (issued and not yet completed) produces no `req_valid` and sets `cmd_err`. Register address 2 reads `cmd_err` in bit 0, and that read clears it.
- R8: A command whose tag is not below `NTAGS` is rejected in the same way as R7.
- R9: Once a tag has completed, it can be issued again.
- R10: After reset, `req_valid`, `reg_rvalid`, `irq` and `cmd_err` are low, all status bits are clear and every DMA base entry is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data, valid the cycle after the read strobe |
| reg_rvalid | output | 1 | Read data valid |
| req_valid | output | 1 | One-cycle push of a request descriptor |
| req_tag | output | 8 | Request tag |
| req_op | output | 8 | Request opcode |
| req_len | output | 16 | Length in 512-byte units |
| req_sector | output | 32 | Internal address in 512-byte units |
| req_dma | output | DMA_AW | Host DMA buffer base for the tag |
| done_valid | input | 1 | Completion strobe from the scheduler |
| done_tag | input | TAG_IW | Tag that completed |
| irq | output | 1 | Completion interrupt, high while status is pending |
| cmd_err | output | 1 | Sticky rejected-command flag |

## Verification
A wrong outstanding-tag bit shows up at the ports one cycle after the next command write to that tag. Either `req_valid` stays low where a push was due, or a push appears with `cmd_err` unchanged where a rejection was due. A status bit that is lost, stuck or cleared too early shows in the very next status read and in `irq`. Each command word and completion pattern therefore gets its own read-back, and in every test the reads alternate with the completions within a cycle or two. A corrupted DMA table entry appears in `req_dma` on the first issue of that tag, so the bench issues every tag after loading the whole table.

// File: rtl/atomic_issue_pkg.sv
package atomic_issue_pkg;
   localparam int CMD_W      = 64;
   localparam int REG_CMD    = 0;
   localparam int REG_STATUS = 1;
   localparam int REG_ERR    = 2;

   typedef struct packed {
      logic [31:0] sector;
      logic [15:0] len;
      logic [7:0]  op;
      logic [7:0]  tag;
   } cmd_word_t;
endpackage

// File: rtl/issue_cmd_decode.sv
module issue_cmd_decode
   import atomic_issue_pkg::*;
#(
   parameter int NTAGS  = 16,
   parameter int ADDR_W = 9,
   localparam int TAG_IW = (NTAGS > 1) ? $clog2(NTAGS) : 1
) (
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [CMD_W-1:0]  wdata,
   input  logic [NTAGS-1:0]  busy,
   output cmd_word_t         cmd,
   output logic [TAG_IW-1:0] idx,
   output logic              accept,
   output logic              reject
);
   logic is_cmd;
   logic in_range;

   always_comb begin
      cmd      = cmd_word_t'(wdata);
      idx      = cmd.tag[TAG_IW-1:0];
      is_cmd   = wr_en && (addr == ADDR_W'(REG_CMD));
      in_range = ({1'b0, cmd.tag} < 9'(NTAGS));
      accept   = is_cmd && in_range && !busy[idx];
      reject   = is_cmd && !accept;
   end
endmodule

// File: rtl/dma_base_table.sv
module dma_base_table #(
   parameter int NTAGS  = 16,
   parameter int DMA_AW = 48,
   localparam int TAG_IW = (NTAGS > 1) ? $clog2(NTAGS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [TAG_IW-1:0] wr_idx,
   input  logic [DMA_AW-1:0] wr_data,
   input  logic [TAG_IW-1:0] rd_idx,
   output logic [DMA_AW-1:0] rd_data
);
   logic [DMA_AW-1:0] entry_q [NTAGS];

   for (genvar t = 0; t < NTAGS; t++) begin : g_entry
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            entry_q[t] <= '0;
         else if (wr_en && (wr_idx == TAG_IW'(t)))
            entry_q[t] <= wr_data;
      end
   end

   assign rd_data = entry_q[rd_idx];
endmodule

// File: rtl/tag_tracker.sv
module tag_tracker #(
   parameter int NTAGS = 16,
   localparam int TAG_IW = (NTAGS > 1) ? $clog2(NTAGS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue_en,
   input  logic [TAG_IW-1:0] issue_idx,
   input  logic              done_en,
   input  logic [TAG_IW-1:0] done_idx,
   input  logic              clr_en,
   output logic [NTAGS-1:0]  busy_q,
   output logic [NTAGS-1:0]  status_q
);
   logic [NTAGS-1:0] iss_oh;
   logic [NTAGS-1:0] done_oh;

   always_comb begin
      iss_oh  = issue_en ? (NTAGS'(1) << issue_idx) : '0;
      done_oh = done_en  ? (NTAGS'(1) << done_idx)  : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q   <= '0;
         status_q <= '0;
      end else begin
         busy_q   <= (busy_q | iss_oh) & ~done_oh;
         // a completion landing with a read survives for the next read
         status_q <= (clr_en ? '0 : status_q) | done_oh;
      end
   end
endmodule

// File: rtl/atomic_issue_regs.sv
module atomic_issue_regs
   import atomic_issue_pkg::*;
#(
   parameter int NTAGS  = 16,
   parameter int DMA_AW = 48,
   parameter int ADDR_W = 9,
   localparam int TAG_IW = (NTAGS > 1) ? $clog2(NTAGS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [63:0]       reg_wdata,
   output logic [63:0]       reg_rdata,
   output logic              reg_rvalid,
   output logic              req_valid,
   output logic [7:0]        req_tag,
   output logic [7:0]        req_op,
   output logic [15:0]       req_len,
   output logic [31:0]       req_sector,
   output logic [DMA_AW-1:0] req_dma,
   input  logic              done_valid,
   input  logic [TAG_IW-1:0] done_tag,
   output logic              irq,
   output logic              cmd_err
);
   if (NTAGS < 1 || NTAGS > 64 || NTAGS != (1 << TAG_IW) && NTAGS > 1)
      $error("NTAGS must be a power of two from 1 to 64");
   if (DMA_AW < 1 || DMA_AW > 64)
      $error("DMA_AW must be 1 to 64");
   if (ADDR_W < TAG_IW + 1 || ADDR_W < 2)
      $error("ADDR_W too small for the table window");

   cmd_word_t         cmd;
   logic [TAG_IW-1:0] cmd_idx;
   logic              accept;
   logic              reject;
   logic [NTAGS-1:0]  busy_q;
   logic [NTAGS-1:0]  status_q;
   logic [DMA_AW-1:0] dma_rd;
   logic [63:0]       status_ext;
   logic              tbl_wr;
   logic              rd_status;
   logic              rd_err;

   always_comb begin
      status_ext            = '0;
      status_ext[NTAGS-1:0] = status_q;
      tbl_wr    = reg_wr && reg_addr[ADDR_W-1];
      rd_status = reg_rd && (reg_addr == ADDR_W'(REG_STATUS));
      rd_err    = reg_rd && (reg_addr == ADDR_W'(REG_ERR));
   end

   issue_cmd_decode #(.NTAGS(NTAGS), .ADDR_W(ADDR_W)) dec_i (
      .wr_en (reg_wr),
      .addr  (reg_addr),
      .wdata (reg_wdata),
      .busy  (busy_q),
      .cmd   (cmd),
      .idx   (cmd_idx),
      .accept(accept),
      .reject(reject)
   );

   dma_base_table #(.NTAGS(NTAGS), .DMA_AW(DMA_AW)) tbl_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (tbl_wr),
      .wr_idx (reg_addr[TAG_IW-1:0]),
      .wr_data(reg_wdata[DMA_AW-1:0]),
      .rd_idx (cmd_idx),
      .rd_data(dma_rd)
   );

   tag_tracker #(.NTAGS(NTAGS)) trk_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .issue_en (accept),
      .issue_idx(cmd_idx),
      .done_en  (done_valid),
      .done_idx (done_tag),
      .clr_en   (rd_status),
      .busy_q   (busy_q),
      .status_q (status_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_valid  <= 1'b0;
         req_tag    <= '0;
         req_op     <= '0;
         req_len    <= '0;
         req_sector <= '0;
         req_dma    <= '0;
      end else begin
         req_valid <= accept;
         if (accept) begin
            req_tag    <= cmd.tag;
            req_op     <= cmd.op;
            req_len    <= cmd.len;
            req_sector <= cmd.sector;
            req_dma    <= dma_rd;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_rdata  <= '0;
         reg_rvalid <= 1'b0;
         cmd_err    <= 1'b0;
      end else begin
         reg_rvalid <= reg_rd;
         if (reg_rd)
            reg_rdata <= rd_status ? status_ext
                       : rd_err    ? {63'b0, cmd_err}
                       : 64'b0;
         if (reject)
            cmd_err <= 1'b1;
         else if (rd_err)
            cmd_err <= 1'b0;
      end
   end

   assign irq = |status_q;
endmodule

// File: rtl/atomic_issue_chk.sv
module atomic_issue_chk #(
   parameter int NTAGS  = 16,
   parameter int ADDR_W = 9,
   localparam int TAG_IW = (NTAGS > 1) ? $clog2(NTAGS) : 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic              reg_rd,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [63:0]       reg_wdata,
   input logic [63:0]       reg_rdata,
   input logic              reg_rvalid,
   input logic              req_valid,
   input logic              done_valid,
   input logic [TAG_IW-1:0] done_tag,
   input logic              irq,
   input logic              cmd_err,
   input logic [NTAGS-1:0]  busy_q,
   input logic [NTAGS-1:0]  status_q
);
   logic        cmd_wr;
   logic        bad_cmd;
   logic        st_rd;
   logic [63:0] st_ext;

   always_comb begin
      cmd_wr  = reg_wr && (reg_addr == ADDR_W'(0));
      bad_cmd = cmd_wr && (({1'b0, reg_wdata[7:0]} >= 9'(NTAGS))
                           || busy_q[reg_wdata[TAG_IW-1:0]]);
      st_rd   = reg_rd && (reg_addr == ADDR_W'(1));
      st_ext  = '0;
      st_ext[NTAGS-1:0] = status_q;
   end

   assert_push_from_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> $past(cmd_wr));

   assert_done_sets_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |=> status_q[$past(done_tag)]);

   assert_read_returns_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
      st_rd |=> (reg_rvalid && reg_rdata == $past(st_ext)));

   assert_race_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (st_rd && done_valid) |=> status_q[$past(done_tag)]);

   assert_irq_drop_on_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq) |-> $past(st_rd));

   assert_reject_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
      bad_cmd |=> (!req_valid && cmd_err));
endmodule

bind atomic_issue_regs atomic_issue_chk #(.NTAGS(NTAGS), .ADDR_W(ADDR_W)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_wr    (reg_wr),
   .reg_rd    (reg_rd),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .reg_rdata (reg_rdata),
   .reg_rvalid(reg_rvalid),
   .req_valid (req_valid),
   .done_valid(done_valid),
   .done_tag  (done_tag),
   .irq       (irq),
   .cmd_err   (cmd_err),
   .busy_q    (busy_q),
   .status_q  (status_q)
);

// File: tb/atomic_issue_regs_tb.sv
module atomic_issue_regs_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NTAGS  = 16;
   localparam int DMA_AW = 48;
   localparam int ADDR_W = 9;
   localparam int TAG_IW = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              reg_wr = 1'b0;
   logic              reg_rd = 1'b0;
   logic [ADDR_W-1:0] reg_addr = '0;
   logic [63:0]       reg_wdata = '0;
   logic [63:0]       reg_rdata;
   logic              reg_rvalid;
   logic              req_valid;
   logic [7:0]        req_tag;
   logic [7:0]        req_op;
   logic [15:0]       req_len;
   logic [31:0]       req_sector;
   logic [DMA_AW-1:0] req_dma;
   logic              done_valid = 1'b0;
   logic [TAG_IW-1:0] done_tag = '0;
   logic              irq;
   logic              cmd_err;

   int n_chk = 0;
   int n_err = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   atomic_issue_regs #(.NTAGS(NTAGS), .DMA_AW(DMA_AW), .ADDR_W(ADDR_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .reg_rvalid(reg_rvalid), .req_valid(req_valid), .req_tag(req_tag),
      .req_op(req_op), .req_len(req_len), .req_sector(req_sector),
      .req_dma(req_dma), .done_valid(done_valid), .done_tag(done_tag),
      .irq(irq), .cmd_err(cmd_err)
   );

   function automatic logic [DMA_AW-1:0] base_of(int t);
      return DMA_AW'(64'h0000_0100_0000_1000 * (t + 1) + 64'h40);
   endfunction

   function automatic logic [63:0] cmd_of(int t, int raw_tag);
      logic [31:0] sec = 32'h1000_0000 + 32'(t * 77);
      logic [15:0] len = 16'(t * 3 + 1);
      logic [7:0]  op  = 8'(t + 1);
      return {sec, len, op, 8'(raw_tag)};
   endfunction

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [ADDR_W-1:0] a, input logic [63:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [ADDR_W-1:0] a, input bit with_done,
                         input int dt, output logic [63:0] d);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = a;
      done_valid = with_done; done_tag = TAG_IW'(dt);
      @(negedge clk);
      reg_rd = 1'b0; done_valid = 1'b0;
      d = reg_rdata;
      check("R4 rvalid", {63'b0, reg_rvalid}, 64'd1);
   endtask

   task automatic complete(input int t);
      @(negedge clk);
      done_valid = 1'b1; done_tag = TAG_IW'(t);
      @(negedge clk);
      done_valid = 1'b0;
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [63:0] rd;
      logic [63:0] mask;
      repeat (3) @(negedge clk);
      // R10 reset state
      check("R10 req_valid", {63'b0, req_valid}, 64'd0);
      check("R10 irq", {63'b0, irq}, 64'd0);
      check("R10 cmd_err", {63'b0, cmd_err}, 64'd0);
      check("R10 rvalid", {63'b0, reg_rvalid}, 64'd0);
      rst_n = 1'b1;
      rd_reg(9'd1, 0, 0, rd);
      check("R10 status clear", rd, 64'd0);
      // R10 table zero: issue tag 1 before loading
      wr_reg(9'd0, cmd_of(1, 1));
      check("R10 table zero", {16'b0, req_dma}, 64'd0);
      complete(1);
      rd_reg(9'd1, 0, 0, rd);
      check("R3 single done", rd, 64'h2);

      // R8 out-of-range tag
      wr_reg(9'd0, cmd_of(2, 18));
      check("R8 no push", {63'b0, req_valid}, 64'd0);
      check("R8 err set", {63'b0, cmd_err}, 64'd1);
      rd_reg(9'd2, 0, 0, rd);
      check("R7 err read", rd, 64'd1);
      check("R7 err cleared", {63'b0, cmd_err}, 64'd0);

      // R2 load table for every tag
      for (int t = 0; t < NTAGS; t++)
         wr_reg(ADDR_W'(256 + t), {16'hDEAD, base_of(t)});

      // R1/R2 issue every tag
      for (int t = 0; t < NTAGS; t++) begin
         wr_reg(9'd0, cmd_of(t, t));
         check("R1 push", {63'b0, req_valid}, 64'd1);
         check("R1 fields", {req_sector, req_len, req_op, req_tag}, cmd_of(t, t));
         check("R2 dma base", {16'b0, req_dma}, {16'b0, base_of(t)});
      end

      // R7 reissue of busy tag
      wr_reg(9'd0, cmd_of(5, 5));
      check("R7 no push", {63'b0, req_valid}, 64'd0);
      check("R7 err set", {63'b0, cmd_err}, 64'd1);
      rd_reg(9'd2, 0, 0, rd);
      check("R7 err read", rd, 64'd1);

      // R3/R4/R6 completions
      check("R6 irq idle", {63'b0, irq}, 64'd0);
      complete(0); complete(3); complete(7); complete(15);
      check("R6 irq pending", {63'b0, irq}, 64'd1);
      rd_reg(9'd1, 0, 0, rd);
      check("R4 mask", rd, 64'h8089);
      check("R6 irq dropped", {63'b0, irq}, 64'd0);
      rd_reg(9'd1, 0, 0, rd);
      check("R4 cleared by read", rd, 64'd0);

      // R5 completion during a read
      complete(8);
      rd_reg(9'd1, 1, 9, rd);
      check("R5 first read", rd, 64'h100);
      check("R6 irq held", {63'b0, irq}, 64'd1);
      rd_reg(9'd1, 0, 0, rd);
      check("R5 kept bit", rd, 64'h200);
      check("R6 irq after", {63'b0, irq}, 64'd0);

      // R9 completed tag reusable
      wr_reg(9'd0, cmd_of(3, 3));
      check("R9 reissue push", {63'b0, req_valid}, 64'd1);
      check("R9 reissue dma", {16'b0, req_dma}, {16'b0, base_of(3)});

      // complete all outstanding, sweep mask
      mask = '0;
      for (int t = 0; t < NTAGS; t++)
         if (!(t == 0 || t == 7 || t == 15 || t == 8 || t == 9)) begin
            complete(t);
            mask[t] = 1'b1;
         end
      rd_reg(9'd1, 0, 0, rd);
      check("R4 sweep mask", rd, mask);
      check("R4 sweep mask value", mask, 64'h7C7E);

      // R9 every tag free again
      for (int t = 0; t < NTAGS; t++) begin
         wr_reg(9'd0, cmd_of(t + 2, t));
         check("R9 push again", {63'b0, req_valid}, 64'd1);
      end
      check("R9 no error", {63'b0, cmd_err}, 64'd0);
      finish_run();
   end
endmodule